// File: doc/BRIEF.md
# Flash Ready/Busy Status Pin Controller

This block drives the ready/busy status pin of a parallel NOR flash and the two error flags of its status register. A configuration write carries a word whose two lowest bits pick one of four modes. The remaining bits are reserved and ignored. In level mode the pin tracks the busy flag of the internal write state machine. In the three pulse modes the pin idles high. When a completion event of the selected kind arrives (erase only, program only, or either), the pin drops low for a fixed number of clock cycles.

A mode code that the build does not support leaves the current mode unchanged and raises both status error flags. The next accepted configuration write clears them. The pulse length is a parameter in clock cycles, chosen as the wanted width (about 500 ns) divided by the clock period. A second completion event during a pulse restarts the count. An accepted configuration write cancels a pulse that is running.

Top module: `sts_pin_ctrl`

## Requirements
- R1: After reset the mode is level (code 00), the status pin is high while the state machine is idle, and both error flags are 0.
- R2: In level mode (code 00) the status pin, one clock after `wsm_busy` is sampled, equals the inverse of that sample: low while busy, high while ready.
- R3: In level mode, `erase_done` and `prog_done` have no effect on the status pin.
- R4: With code 01 an `erase_done` pulse drives the pin low, and a `prog_done` alone does not.
- R5: With code 10 a `prog_done` pulse drives the pin low, and an `erase_done` alone does not.
- R6: With code 11 either completion event, or both in the same cycle, drives the pin low. Both in one cycle give a single pulse.
- R7: A pulse holds the pin low for exactly `PULSE_CYC` cycles, starting on the clock edge that samples the accepted event. The pin is then high.
- R8: In a pulse mode the pin is high whenever no pulse is active, whatever `wsm_busy` is.
- R9: Data bits above bit 1 of a configuration write are ignored.
- R10: A write of a code whose bit in `MODE_MASK` is 0 sets both `sr_erase_err` and `sr_prog_err` and keeps the previous mode.
- R11: A write of a supported code clears both error flags and takes effect from the next cycle.
- R12: An accepted event that arrives while a pulse is active restarts the pulse at full length.
- R13: A supported configuration write ends an active pulse. A completion event sampled in the same cycle as the write is filtered by the mode in force before the write, and if accepted it starts a pulse that survives the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_data | input | CFG_W | Configuration word; bits [1:0] hold the mode code |
| wsm_busy | input | 1 | Write state machine busy flag |
| erase_done | input | 1 | One-cycle erase completion event |
| prog_done | input | 1 | One-cycle program completion event |
| sts_n | output | 1 | Status pin; low means busy (level mode) or pulse active |
| sr_erase_err | output | 1 | Status-register erase error flag, set on an unsupported code |
| sr_prog_err | output | 1 | Status-register program error flag, set on an unsupported code |

## Verification
A configuration write and a completion event can fall in the same cycle, and so can a new event and a pulse already running. The bench drives a write from erase-only to program-only in the same cycle as `erase_done`, and then the reverse. It expects a full pulse in the first case and none in the second, because the old mode does the filtering. It also fires a second event two cycles into a pulse and counts the low cycles from the second event to judge the restart.

// File: rtl/sts_pin_pkg.sv
package sts_pin_pkg;

  typedef enum logic [1:0] {
    STS_LEVEL = 2'b00,
    STS_ERASE = 2'b01,
    STS_PROG  = 2'b10,
    STS_ANY   = 2'b11
  } sts_mode_e;

  // Does a completion event start a pulse in the given mode?
  function automatic logic fn_accept(sts_mode_e m, logic erase_ev, logic prog_ev);
    case (m)
      STS_ERASE: return erase_ev;
      STS_PROG:  return prog_ev;
      STS_ANY:   return erase_ev | prog_ev;
      default:   return 1'b0;
    endcase
  endfunction

  // Is a mode code supported by this build?
  function automatic logic fn_code_ok(logic [3:0] mask, logic [1:0] code);
    return mask[code];
  endfunction

endpackage

// File: rtl/sts_cfg_reg.sv
module sts_cfg_reg
  import sts_pin_pkg::*;
#(
  parameter int         CFG_W     = 8,
  parameter logic [3:0] MODE_MASK = 4'b1111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  output sts_mode_e        mode_q,
  output logic             err_q,
  output logic             wr_ok,
  output logic             wr_bad
);

  localparam int RSV_W = CFG_W - 2;

  logic [1:0]       code;
  logic [RSV_W-1:0] rsv_bits;

  assign code     = cfg_data[1:0];
  assign rsv_bits = cfg_data[CFG_W-1:2];
  assign wr_ok    = cfg_we &  fn_code_ok(MODE_MASK, code);
  assign wr_bad   = cfg_we & ~fn_code_ok(MODE_MASK, code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= STS_LEVEL;
      err_q  <= 1'b0;
    end else if (wr_ok) begin
      mode_q <= sts_mode_e'(code);
      err_q  <= 1'b0;
    end else if (wr_bad) begin
      err_q  <= 1'b1;
    end
  end

  // R10
  bad_code_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> err_q && mode_q == $past(mode_q));

  // R11
  good_code_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !err_q && mode_q == sts_mode_e'($past(code)));

  // R9
  rsv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rsv_bits != '0) |=> mode_q == sts_mode_e'($past(cfg_data[1:0])));

endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int PULSE_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cancel,
  output logic active
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= FULL;
    else if (cancel)        cnt <= '0;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R12
  restart_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && active) |=> cnt == FULL);

  // R13
  cancel_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !load) |=> !active);

endmodule

// File: rtl/sts_pin_ctrl.sv
module sts_pin_ctrl
  import sts_pin_pkg::*;
#(
  parameter int         CFG_W     = 8,
  parameter int         PULSE_CYC = 25,
  parameter logic [3:0] MODE_MASK = 4'b1111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             wsm_busy,
  input  logic             erase_done,
  input  logic             prog_done,
  output logic             sts_n,
  output logic             sr_erase_err,
  output logic             sr_prog_err
);

  sts_mode_e mode_q;
  logic      err_q;
  logic      wr_ok;
  logic      wr_bad;
  logic      busy_q;
  logic      ev_accept;
  logic      pulse_on;

  sts_cfg_reg #(.CFG_W(CFG_W), .MODE_MASK(MODE_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .mode_q(mode_q), .err_q(err_q), .wr_ok(wr_ok), .wr_bad(wr_bad)
  );

  // Filtered by the mode in force before any same-cycle write.
  assign ev_accept = fn_accept(mode_q, erase_done, prog_done);

  sts_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .cancel(wr_ok),
    .active(pulse_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= wsm_busy;
  end

  assign sts_n        = (mode_q == STS_LEVEL) ? ~busy_q : ~pulse_on;
  assign sr_erase_err = err_q;
  assign sr_prog_err  = err_q;

  // R2
  level_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && mode_q == STS_LEVEL) |=> sts_n == !$past(wsm_busy));

  // R7
  pulse_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !cfg_we) |=> !sts_n);

  // R3
  level_ignores_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == STS_LEVEL) |-> !ev_accept);

endmodule

// File: tb/sts_pin_ctrl_tb.sv
module sts_pin_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       wsm_busy = 1'b0;
  logic       erase_done = 1'b0;
  logic       prog_done = 1'b0;
  logic       sts_n, e_err, p_err;
  logic       sts_n_alt, e_err_alt, p_err_alt;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sts_pin_ctrl #(.CFG_W(8), .PULSE_CYC(P), .MODE_MASK(4'b1111)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .wsm_busy(wsm_busy), .erase_done(erase_done), .prog_done(prog_done),
    .sts_n(sts_n), .sr_erase_err(e_err), .sr_prog_err(p_err)
  );

  // Code 10 unsupported in this build.
  sts_pin_ctrl #(.CFG_W(8), .PULSE_CYC(P), .MODE_MASK(4'b1011)) u_alt (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .wsm_busy(wsm_busy), .erase_done(erase_done), .prog_done(prog_done),
    .sts_n(sts_n_alt), .sr_erase_err(e_err_alt), .sr_prog_err(p_err_alt)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change only just after a falling edge.
  task automatic cfg_write(logic [7:0] w);
    cfg_we = 1'b1; cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = '0;
  endtask

  task automatic fire(logic e, logic p);
    erase_done = e; prog_done = p;
    @(negedge clk);
    erase_done = 1'b0; prog_done = 1'b0;
  endtask

  // Watch the pin for P+2 cycles after an event; low for the first P when accepted.
  task automatic watch_pulse(string req, logic acc);
    for (int k = 0; k < P + 2; k++) begin
      chk(req, sts_n, !(acc && k < P));
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 sts", sts_n, 1'b1);
    chk("R1 err5", e_err, 1'b0);
    chk("R1 err4", p_err, 1'b0);

    // R2: busy sweep in level mode
    for (int i = 0; i < 6; i++) begin
      wsm_busy = ((i * 5) % 3) == 1;
      @(negedge clk);
      chk("R2 level", sts_n, !wsm_busy);
    end
    // R3: events ignored in level mode
    wsm_busy = 1'b1;
    fire(1'b1, 1'b1);
    chk("R3 busy", sts_n, 1'b0);
    wsm_busy = 1'b0;
    fire(1'b1, 1'b0);
    chk("R3 ready", sts_n, 1'b1);
    fire(1'b0, 1'b1);
    chk("R3 ready", sts_n, 1'b1);

    // R4 R5 R6 R7 R8 R9: sweep over modes, events and reserved bits
    for (int m = 1; m < 4; m++) begin
      for (int ev = 1; ev < 4; ev++) begin
        cfg_write({6'((m * 13 + ev * 7) & 63), 2'(m)});
        wsm_busy = ev[0];
        chk("R8 idle", sts_n, 1'b1);
        fire(ev[0], ev[1]);
        watch_pulse(m == 1 ? "R4" : (m == 2 ? "R5" : "R6 R7 R9"), (m & ev) != 0);
      end
    end
    wsm_busy = 1'b0;

    // R12: restart during pulse
    cfg_write(8'h03);
    fire(1'b1, 1'b0);
    @(negedge clk);
    chk("R12 mid", sts_n, 1'b0);
    fire(1'b0, 1'b1);
    watch_pulse("R12", 1'b1);

    // R13: write cancels an active pulse
    fire(1'b1, 1'b0);
    chk("R13 low", sts_n, 1'b0);
    cfg_write(8'h03);
    chk("R13 cancel", sts_n, 1'b1);

    // R13: same-cycle write and event, old mode filters
    cfg_write(8'h01);
    cfg_we = 1'b1; cfg_data = 8'h02; erase_done = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = '0; erase_done = 1'b0;
    watch_pulse("R13 accept", 1'b1);
    cfg_we = 1'b1; cfg_data = 8'h01; erase_done = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = '0; erase_done = 1'b0;
    watch_pulse("R13 drop", 1'b0);

    // R10 R11 on the build lacking code 10
    cfg_write(8'h01);
    chk("R11 clear5", e_err_alt, 1'b0);
    cfg_write(8'hA2);
    chk("R10 err5", e_err_alt, 1'b1);
    chk("R10 err4", p_err_alt, 1'b1);
    fire(1'b1, 1'b0);
    chk("R10 kept mode", sts_n_alt, 1'b0);
    repeat (P) @(negedge clk);
    fire(1'b0, 1'b1);
    chk("R10 no prog", sts_n_alt, 1'b1);
    cfg_write(8'h03);
    chk("R11 clear5", e_err_alt, 1'b0);
    chk("R11 clear4", p_err_alt, 1'b0);
    fire(1'b0, 1'b1);
    chk("R11 new mode", sts_n_alt, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule